// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block is a Clause 22 MDIO management master driven by one 32-bit control word. Host software writes the word with the PHY and register addresses, a read or write selector, an enable bit and a busy bit. For a write it also supplies 16 bits of data. The block then sends a full management frame on MDC/MDIO. When the frame ends, hardware clears busy. For a read, the 16 bits returned by the PHY replace the low half of the same word.

Software starts a transaction by writing the word with busy set. It then polls the word until busy reads back as zero. Every accepted frame takes the same fixed number of system clocks, so a bounded poll loop is enough. Commands the block cannot send complete at once without any bus activity. These are a start with the enable bit clear, or a PHY address outside the supported range.

Top module: `mdio_ctl_master`

## Requirements
- R1: After reset the control word reads 0, MDC is low and the MDIO output enable is low.
- R2: Control word layout: bits [15:0] data, [20:16] register address, [25:21] PHY address, bit 27 read (1) / write (0), bit 30 enable, bit 31 busy. A write accepted while busy is clear stores the whole word, and it reads back unchanged. A word written with bit 31 clear starts nothing.
- R3: A start happens only when busy=1, enable=1 and the PHY address is below NUM_PHYS (5). It sends 64 bits, MSB first within each field:
  - 32 ones;
  - start 01;
  - opcode 10 for a read or 01 for a write;
  - the PHY address, then the register address;
  - turnaround 10 and the 16 data bits (write only).
- R4: MDC is low whenever no frame is running. During a frame its period is 2*HALF_DIV system clocks, high for HALF_DIV. MDIO output changes only at the falling MDC edge, so a frame holds MDC high for exactly 64*HALF_DIV clocks.
- R5: On a read the master drives MDIO for the first 46 bits and releases it for the last 18. It samples MDIO on the rising MDC edge of bits 48..63. The first sampled bit becomes data bit 15.
- R6: Busy clears exactly 128*HALF_DIV system clocks after the edge that accepted a valid start. All other fields are unchanged, except that a read overwrites bits [15:0] with the sampled data.
- R7: A write to the control word while busy is set has no effect.
- R8: A word with busy=1 and enable=0 sends no frame. Busy clears one clock after acceptance and the other bits are kept.
- R9: A word with busy=1, enable=1 and PHY address >= NUM_PHYS sends no frame, and busy clears one clock after acceptance. For a read, bits [15:0] become 16'hFFFF. For a write, they are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Current control word |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |

## Verification
The bench reads the control word on the falling system clock edge. It counts those samples from the accepting edge until busy reads zero. The count is due at 128*HALF_DIV for a valid start, 1 for a rejected command and 0 for a word without busy. Frame bits and the output enable are captured at each rising MDC edge, when the master holds them stable. A model PHY presents its next bit right after each rising edge, so the master sees it a full MDC period before it samples. The final word, the captured frame, the MDC-high count and the idle levels are checked once busy has cleared.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = 6;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    typedef struct packed {
        logic        busy;
        logic        enable;
        logic [1:0]  spare_hi;
        logic        rd;
        logic        spare_lo;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } ctl_word_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = run && (st_q.cnt == CW'(HALF_DIV - 1));
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        rise_evt = wrap && !st_q.mdc;
        fall_evt = wrap && st_q.mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;

    // R4
    mdc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(run));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_rd,
    input  logic [4:0]  start_phy,
    input  logic [4:0]  start_reg,
    input  logic [15:0] start_wdata,
    input  logic        rise_evt,
    input  logic        fall_evt,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int FRAME_CYC = 2 * HALF_DIV * FRAME_BITS;

    typedef struct packed {
        logic                  active;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [15:0]           rdata;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = st_q.active && fall_evt && (st_q.idx == IDX_W'(FRAME_BITS - 1));
        if (start) begin
            st_d.active = 1'b1;
            st_d.rd     = start_rd;
            st_d.idx    = '0;
            st_d.rdata  = '0;
            st_d.sh     = {32'hFFFF_FFFF, 2'b01,
                           start_rd ? 2'b10 : 2'b01,
                           start_phy, start_reg,
                           start_rd ? 2'b11 : 2'b10,
                           start_rd ? 16'h0000 : start_wdata};
        end else if (st_q.active) begin
            if (rise_evt && st_q.rd && (st_q.idx >= IDX_W'(DATA_POS)))
                st_d.rdata = {st_q.rdata[14:0], mdio_i};
            if (done) begin
                st_d.active = 1'b0;
            end else if (fall_evt) begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign rdata   = st_q.rdata;
    assign mdio_oe = st_q.active && (!st_q.rd || (st_q.idx < IDX_W'(TA_POS)));
    assign mdio_o  = st_q.active && st_q.sh[FRAME_BITS-1];

    // frame length counter for checking only
    int len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  len_q <= 0;
        else if (!st_q.active)       len_q <= 0;
        else                         len_q <= len_q + 1;
    end

    // R6
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len_q == FRAME_CYC - 1));

    // R5
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $rose(active));

    // R4
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(fall_evt)) |-> $stable(mdio_o));

endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int NUM_PHYS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    ctl_word_t   ctl_d, ctl_q;
    ctl_word_t   wr_word;
    logic        accept;
    logic        start;
    logic        seq_active;
    logic        seq_done;
    logic [15:0] seq_rdata;
    logic        rise_evt;
    logic        fall_evt;

    assign wr_word = ctl_word_t'(ctl_wdata);

    always_comb begin
        ctl_d  = ctl_q;
        accept = ctl_wr && !ctl_q.busy;
        start  = accept && wr_word.busy && wr_word.enable &&
                 (32'(wr_word.phy) < NUM_PHYS);
        if (accept) begin
            ctl_d = wr_word;
        end else if (ctl_q.busy) begin
            if (seq_done) begin
                ctl_d.busy = 1'b0;
                if (ctl_q.rd) ctl_d.data = seq_rdata;
            end else if (!seq_active) begin
                ctl_d.busy = 1'b0;
                if (ctl_q.enable && ctl_q.rd && (32'(ctl_q.phy) >= NUM_PHYS))
                    ctl_d.data = 16'hFFFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_rdata = ctl_q;

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_active),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_seq #(.HALF_DIV(HALF_DIV)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_rd    (wr_word.rd),
        .start_phy   (wr_word.phy),
        .start_reg   (wr_word.regad),
        .start_wdata (wr_word.data),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .mdio_i      (mdio_i),
        .active      (seq_active),
        .done        (seq_done),
        .rdata       (seq_rdata),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe)
    );

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && seq_active && !seq_done) |=> $stable(ctl_q));

    // R6
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.busy) |-> ($past(seq_done) || !$past(seq_active)));

    // R4
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_active |-> !mdc);

endmodule

// File: tb/mdio_ctl_master_tb_top.sv
module mdio_ctl_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int NUM_PHYS   = 5;
    localparam int FRAME_CYC  = 128 * HALF_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;

    logic [63:0] cap_o, cap_oe;
    int          rise_cnt = 0;
    logic [15:0] phy_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_ctl_master #(.HALF_DIV(HALF_DIV), .NUM_PHYS(NUM_PHYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    function automatic logic phy_bit(int k);
        if (k >= 48 && k < 64) return phy_val[63-k];
        if (k == 47) return 1'b0;
        return 1'b1;
    endfunction

    // model PHY and frame capture on rising MDC
    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_o[63-rise_cnt]  = mdio_o;
            cap_oe[63-rise_cnt] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
        mdio_i = phy_bit(rise_cnt);
    end

    function automatic logic [63:0] exp_frame(logic rd, logic [4:0] phy,
                                              logic [4:0] rg, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
                rd ? 2'b00 : 2'b10, rd ? 16'h0000 : d};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(logic [31:0] word, logic [15:0] pv,
                           bit intr, logic [31:0] intruder);
        int busy_cycles = 0;
        int hi_cnt = 0;
        bit valid, rd;
        logic [31:0] exp_w;
        logic [63:0] mask, ef;
        phy_val  = pv;
        rise_cnt = 0;
        mdio_i   = 1'b1;
        cap_o    = '0;
        cap_oe   = '0;
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = word;
        @(negedge clk);
        ctl_wr = 1'b0;
        while (ctl_rdata[31] && busy_cycles < 100000) begin
            busy_cycles++;
            if (mdc) hi_cnt++;
            if (intr && busy_cycles == 4)
                chk(ctl_rdata == word, "R7 write while busy ignored", 64'(ctl_rdata), 64'(word));
            if (intr && busy_cycles == 3) begin
                ctl_wr = 1'b1; ctl_wdata = intruder;
            end else begin
                ctl_wr = 1'b0;
            end
            @(negedge clk);
        end
        ctl_wr = 1'b0;
        valid = word[31] && word[30] && (int'(word[25:21]) < NUM_PHYS);
        rd    = word[27];
        exp_w = word;
        exp_w[31] = 1'b0;
        if (valid && rd) exp_w[15:0] = pv;
        else if (!valid && word[31] && word[30] && rd) exp_w[15:0] = 16'hFFFF;
        chk(busy_cycles == (valid ? FRAME_CYC : (word[31] ? 1 : 0)),
            valid ? "R6 busy duration" : (word[30] ? "R9 reject duration" : "R8 disabled duration"),
            64'(busy_cycles), 64'(valid ? FRAME_CYC : (word[31] ? 1 : 0)));
        chk(ctl_rdata == exp_w, rd ? "R5 R9 final word" : "R2 R8 final word",
            64'(ctl_rdata), 64'(exp_w));
        chk(rise_cnt == (valid ? 64 : 0), "R3 MDC rising edge count",
            64'(rise_cnt), 64'(valid ? 64 : 0));
        chk(hi_cnt == (valid ? 64 * HALF_DIV : 0), "R4 MDC high clocks",
            64'(hi_cnt), 64'(valid ? 64 * HALF_DIV : 0));
        chk(!mdc && !mdio_oe, "R4 idle levels after frame", {mdc, mdio_oe}, 64'd0);
        if (valid) begin
            mask = rd ? {{46{1'b1}}, 18'd0} : '1;
            ef   = exp_frame(rd, word[25:21], word[20:16], word[15:0]);
            chk(cap_oe == mask, "R5 output enable pattern", cap_oe, mask);
            chk((cap_o & mask) == (ef & mask), "R3 frame bits", cap_o & mask, ef & mask);
        end
    endtask

    function automatic logic [31:0] mk(logic rd, logic [4:0] phy, logic [4:0] rg,
                                       logic [15:0] d, logic en);
        return {1'b1, en, 2'b00, rd, 1'b0, phy, rg, d};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1D0C_5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(ctl_rdata == 32'h0, "R1 reset word", 64'(ctl_rdata), 64'd0);
        chk(!mdc && !mdio_oe, "R1 reset MDC and enable", {mdc, mdio_oe}, 64'd0);

        // R2: store without busy
        run_cmd(32'h4BAD_1234, 16'h0, 1'b0, 32'h0);
        // directed frames (R3, R5)
        run_cmd(mk(1'b1, 5'd4, 5'd31, 16'h0000, 1'b1), 16'h0000, 1'b0, 32'h0);
        run_cmd(mk(1'b1, 5'd0, 5'd0, 16'h5555, 1'b1), 16'hFFFF, 1'b0, 32'h0);
        run_cmd(mk(1'b0, 5'd0, 5'd31, 16'hA5A5, 1'b1), 16'h0, 1'b0, 32'h0);
        run_cmd(mk(1'b1, 5'd3, 5'd2, 16'h0, 1'b1), 16'h8001, 1'b0, 32'h0);
        // R7: write while busy
        run_cmd(mk(1'b0, 5'd1, 5'd9, 16'hC3C3, 1'b1), 16'h0, 1'b1, 32'hC000_FFFF);
        run_cmd(mk(1'b1, 5'd2, 5'd17, 16'h0, 1'b1), 16'h1357, 1'b1, 32'h0000_0000);
        // R8: enable clear
        run_cmd(mk(1'b1, 5'd1, 5'd1, 16'h7777, 1'b0), 16'h0, 1'b0, 32'h0);
        run_cmd(mk(1'b0, 5'd1, 5'd1, 16'h6666, 1'b0), 16'h0, 1'b0, 32'h0);
        // R9: PHY address out of range
        run_cmd(mk(1'b1, 5'd5, 5'd3, 16'h1234, 1'b1), 16'h0, 1'b0, 32'h0);
        run_cmd(mk(1'b0, 5'd31, 5'd3, 16'h4321, 1'b1), 16'h0, 1'b0, 32'h0);
        // random traffic
        for (int i = 0; i < 30; i++) begin
            logic [31:0] w;
            w = mk(1'(($urandom) & 1), 5'($urandom % NUM_PHYS), 5'($urandom),
                   16'($urandom), 1'b1);
            w[29:28] = 2'($urandom);
            w[26]    = 1'($urandom);
            run_cmd(w, 16'($urandom), (i % 5) == 0, $urandom);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule